// File: doc/BRIEF.md
# Multiplexed Vacuum-Fluorescent Display Scanner with Duty Dimmer

This block produces the time-multiplexed drive for a high-voltage fluorescent display panel with up to 25 outputs. The scan is divided into digit periods of a fixed number of oscillator ticks. In each period exactly one grid output is lit and the segment outputs carry that timing's pattern, fetched ahead of time from a display RAM. A programmable share at the start of every period is held dark, which sets the panel's brightness in four steps. Up to sixteen timings are scanned, from the highest down to the first, and the scan then repeats with no idle time between periods.

A mode input chooses the pin where the grids start. Pins below that point are segments and pins from it upward are grids. A second mode input hands the top one, two or three pins to a small general-purpose output port. Those pins then show port data and are never touched by the scan. The oscillator tick arrives as a clock enable on the system clock. The RAM is synchronous with one cycle of read latency, and each of its words holds one timing's pattern, with bit p belonging to pin p. The phase counter, the timing index and the dark-window flag are brought out so that a bench can follow the scan.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: `phase_cnt` advances by one on each clock with `osc_en` high, holds when `osc_en` is low, and returns to 0 after PERIOD-1 (default 768). There is no gap between one period and the next.
- R2: `blank_win` is high while `phase_cnt` is below PERIOD*(16-L)/16, where L is 15, 6, 4 or 3 for `duty_sel` 11, 10, 01 or 00. With the default period that is 48, 480, 576 or 624 ticks. On the clock after a dark cycle, every non-port pin of `drive` is 0.
- R3: `count_sel` value c selects 16-c timings. Values 1011 to 1111 all select 5 timings.
- R4: `timing_idx` (0 means the first timing) changes only when the phase wraps. The next index is N-1 when the index is 0 or is not below the current count N, and index-1 otherwise. The first period after reset is a dark lead-in at index 0, so the real scan starts with the highest timing.
- R5: While `disp_on` is 0, every non-port pin of `drive` is 0 one clock later.
- R6: `pin_mode` 00 makes pin 24 a port pin. 01 makes pins 24 and 23 ports, 10 makes pins 24, 23 and 22 ports, and 11 leaves no port pins. Pin 24 shows `port_data[0]`, pin 23 shows bit 1 and pin 22 shows bit 2. Port pins follow the port data one clock later, regardless of scan, dimming or display state.
- R7: During reset `drive` is all zero and `phase_cnt` and `timing_idx` are 0.
- R8: The first grid pin S is 18-g for `grid_sel` value g, and values 1010 to 1111 all give 8. When scanning is lit, the only driven pin at or above S is S+N-1-idx, and only if that pin exists and is not a port pin.
- R9: `ram_rd` pulses for one clock on the tick where `phase_cnt` equals PERIOD-3, with `ram_addr` set to the next timing index. Each pin p below S shows bit p of the word fetched for the current timing, so segment data changes only at period boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Oscillator tick enable |
| disp_on | input | 1 | 1 lights the scan, 0 blanks it |
| duty_sel | input | 2 | Brightness step (lit share of each period) |
| count_sel | input | 4 | Number-of-timings code |
| grid_sel | input | 4 | First grid pin code |
| pin_mode | input | 2 | Port/scan assignment of the top three pins |
| port_data | input | NUM_PORTS | Data for the port pins |
| ram_rdata | input | NUM_PINS | Display RAM read data, one cycle after the strobe |
| ram_rd | output | 1 | Display RAM read strobe |
| ram_addr | output | IDX_W | Display RAM word address (timing index) |
| drive | output | NUM_PINS | Active-high pin drive |
| phase_cnt | output | PH_W | Tick position inside the digit period |
| timing_idx | output | IDX_W | Current timing index |
| blank_win | output | 1 | High during the dark part of the period |

## Verification
A wrong phase count moves the dark window and the period boundary. The grid and segment pins then differ from the reference within one clock of the first misplaced tick, and the mismatch shows on `phase_cnt` at once. A wrong timing index or a stale prefetch register shows at the next period boundary: either the lit grid pin is wrong or the segment pins carry another timing's word. That is at most one period (768 ticks) after the fault. Faults in the port or pin decoding show on the first lit cycle after the mode changes, and the read strobe and address are compared on the tick where they are issued.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    // Width of the decoded configuration numbers (pin numbers, counts).
    localparam int CFG_FW = 8;

    typedef logic [CFG_FW-1:0] cfg_num_t;

    typedef enum logic [1:0] {
        DUTY_3_16  = 2'b00,
        DUTY_4_16  = 2'b01,
        DUTY_6_16  = 2'b10,
        DUTY_15_16 = 2'b11
    } duty_e;

    typedef enum logic [1:0] {
        PINS_P0       = 2'b00,
        PINS_P0_P1    = 2'b01,
        PINS_P0_P2    = 2'b10,
        PINS_ALL_SCAN = 2'b11
    } pin_mode_e;

    // Decoded scan configuration carried to the pin multiplexer.
    typedef struct packed {
        logic     disp_on;
        cfg_num_t n_timings;
        cfg_num_t grid_start;
        cfg_num_t n_ports;
    } scan_cfg_t;

    // Lit share of one period, in sixteenths.
    function automatic int lit_sixteenths(duty_e d);
        case (d)
            DUTY_15_16: return 15;
            DUTY_6_16:  return 6;
            DUTY_4_16:  return 4;
            default:    return 3;
        endcase
    endfunction

    // Number of dark ticks at the start of each period.
    function automatic int dark_ticks(int period, duty_e d);
        return (period * (16 - lit_sixteenths(d))) / 16;
    endfunction

    function automatic int timings_for(logic [3:0] code, int most, int least);
        int v;
        v = most - int'(code);
        if (v < least) v = least;
        return v;
    endfunction

    function automatic int first_grid_pin(logic [3:0] code, int base, int lowest);
        int v;
        v = base - int'(code);
        if (v < lowest) v = lowest;
        return v;
    endfunction

    function automatic int ports_for(pin_mode_e m);
        case (m)
            PINS_P0:    return 1;
            PINS_P0_P1: return 2;
            PINS_P0_P2: return 3;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/vfd_period_timer.sv
module vfd_period_timer
    import vfd_scan_pkg::*;
#(
    parameter int PERIOD = 768,
    parameter int PH_W   = $clog2(PERIOD)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  duty_e           duty,
    output logic [PH_W-1:0] phase,
    output logic            wrap,
    output logic            prefetch,
    output logic            blank
);

    localparam logic [PH_W-1:0] LAST  = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] FETCH = PH_W'(PERIOD - 3);

    logic [PH_W-1:0] dark_len;

    always_comb dark_len = PH_W'(dark_ticks(PERIOD, duty));

    assign wrap     = tick && (phase == LAST);
    assign prefetch = tick && (phase == FETCH);
    assign blank    = (phase < dark_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == LAST) ? '0 : phase + PH_W'(1);
        end
    end

endmodule

// File: rtl/vfd_timing_seq.sv
module vfd_timing_seq
    import vfd_scan_pkg::*;
#(
    parameter int NUM_PINS    = 25,
    parameter int MAX_TIMINGS = 16,
    parameter int IDX_W       = $clog2(MAX_TIMINGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wrap,
    input  logic                prefetch,
    input  cfg_num_t            n_timings,
    input  logic [NUM_PINS-1:0] ram_rdata,
    output logic [IDX_W-1:0]    ram_addr,
    output logic                ram_rd,
    output logic [IDX_W-1:0]    idx,
    output logic                primed,
    output logic [NUM_PINS-1:0] seg_cur
);

    logic [IDX_W-1:0]    nxt;
    logic                beyond;
    logic                pend;
    logic [NUM_PINS-1:0] seg_next;

    // Scan runs downward; index 0 or an index left over from a larger
    // count restarts at the highest timing.
    assign beyond   = (CFG_FW'(idx) >= n_timings);
    assign nxt      = (idx == '0 || beyond) ? IDX_W'(n_timings - CFG_FW'(1))
                                            : idx - IDX_W'(1);
    assign ram_addr = nxt;
    assign ram_rd   = prefetch;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            primed   <= 1'b0;
            pend     <= 1'b0;
            seg_next <= '0;
            seg_cur  <= '0;
        end else begin
            pend <= prefetch;
            if (pend) begin
                seg_next <= ram_rdata;
            end
            if (wrap) begin
                idx     <= nxt;
                primed  <= 1'b1;
                seg_cur <= seg_next;
            end
        end
    end

endmodule

// File: rtl/vfd_pin_mux.sv
module vfd_pin_mux
    import vfd_scan_pkg::*;
#(
    parameter int NUM_PINS  = 25,
    parameter int NUM_PORTS = 3,
    parameter int IDX_W     = 4
) (
    input  scan_cfg_t            cfg,
    input  logic                 blank,
    input  logic                 primed,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_PINS-1:0]  seg_cur,
    input  logic [NUM_PORTS-1:0] port_data,
    output logic [NUM_PINS-1:0]  drive_next
);

    localparam int PORT_BASE = NUM_PINS - NUM_PORTS;

    cfg_num_t idx_w;
    cfg_num_t grid_pin;
    logic     grid_live;
    logic     scan_en;

    assign idx_w     = CFG_FW'(idx);
    assign grid_live = (idx_w < cfg.n_timings);
    assign grid_pin  = cfg.grid_start + cfg.n_timings - CFG_FW'(1) - idx_w;
    assign scan_en   = cfg.disp_on & ~blank & primed;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam cfg_num_t PIN_ID = CFG_FW'(p);
        logic scan_bit;

        assign scan_bit = (PIN_ID < cfg.grid_start) ? seg_cur[p]
                                                    : (grid_live && (grid_pin == PIN_ID));

        if (p >= PORT_BASE) begin : g_dual
            localparam int       PB   = NUM_PINS - 1 - p;
            localparam cfg_num_t RANK = CFG_FW'(PB);
            assign drive_next[p] = (RANK < cfg.n_ports) ? port_data[PB]
                                                        : (scan_en & scan_bit);
        end else begin : g_scan
            assign drive_next[p] = scan_en & scan_bit;
        end
    end

endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
    import vfd_scan_pkg::*;
#(
    parameter int NUM_PINS    = 25,
    parameter int NUM_PORTS   = 3,
    parameter int MAX_TIMINGS = 16,
    parameter int MIN_TIMINGS = 5,
    parameter int PERIOD      = 768,
    parameter int GRID_BASE   = 18,
    parameter int GRID_LOWEST = 8,
    parameter int IDX_W       = $clog2(MAX_TIMINGS),
    parameter int PH_W        = $clog2(PERIOD)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 osc_en,
    input  logic                 disp_on,
    input  logic [1:0]           duty_sel,
    input  logic [3:0]           count_sel,
    input  logic [3:0]           grid_sel,
    input  logic [1:0]           pin_mode,
    input  logic [NUM_PORTS-1:0] port_data,
    input  logic [NUM_PINS-1:0]  ram_rdata,
    output logic                 ram_rd,
    output logic [IDX_W-1:0]     ram_addr,
    output logic [NUM_PINS-1:0]  drive,
    output logic [PH_W-1:0]      phase_cnt,
    output logic [IDX_W-1:0]     timing_idx,
    output logic                 blank_win
);

    scan_cfg_t           cfg;
    logic                wrap;
    logic                prefetch;
    logic                primed;
    logic [NUM_PINS-1:0] seg_cur;
    logic [NUM_PINS-1:0] drive_next;

    always_comb begin
        cfg.disp_on    = disp_on;
        cfg.n_timings  = CFG_FW'(timings_for(count_sel, MAX_TIMINGS, MIN_TIMINGS));
        cfg.grid_start = CFG_FW'(first_grid_pin(grid_sel, GRID_BASE, GRID_LOWEST));
        cfg.n_ports    = CFG_FW'(ports_for(pin_mode_e'(pin_mode)));
    end

    vfd_period_timer #(
        .PERIOD (PERIOD),
        .PH_W   (PH_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (osc_en),
        .duty     (duty_e'(duty_sel)),
        .phase    (phase_cnt),
        .wrap     (wrap),
        .prefetch (prefetch),
        .blank    (blank_win)
    );

    vfd_timing_seq #(
        .NUM_PINS    (NUM_PINS),
        .MAX_TIMINGS (MAX_TIMINGS),
        .IDX_W       (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wrap      (wrap),
        .prefetch  (prefetch),
        .n_timings (cfg.n_timings),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_rd    (ram_rd),
        .idx       (timing_idx),
        .primed    (primed),
        .seg_cur   (seg_cur)
    );

    vfd_pin_mux #(
        .NUM_PINS  (NUM_PINS),
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_mux (
        .cfg        (cfg),
        .blank      (blank_win),
        .primed     (primed),
        .idx        (timing_idx),
        .seg_cur    (seg_cur),
        .port_data  (port_data),
        .drive_next (drive_next)
    );

    // Registered pin drive: no combinational path from the mode inputs
    // to the high-voltage output stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            drive <= '0;
        end else begin
            drive <= drive_next;
        end
    end

endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk #(
    parameter int NUM_PINS    = 25,
    parameter int PERIOD      = 768,
    parameter int GRID_BASE   = 18,
    parameter int GRID_LOWEST = 8,
    parameter int IDX_W       = 4,
    parameter int PH_W        = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                osc_en,
    input logic                disp_on,
    input logic [1:0]          pin_mode,
    input logic [3:0]          grid_sel,
    input logic [NUM_PINS-1:0] drive,
    input logic [PH_W-1:0]     phase_cnt,
    input logic [IDX_W-1:0]    timing_idx,
    input logic                blank_win
);

    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    logic [NUM_PINS-1:0] port_mask;
    logic [NUM_PINS-1:0] upper_mask;
    logic                rst_q;

    always_comb begin
        int start;
        int nports;
        start  = GRID_BASE - int'(grid_sel);
        if (start < GRID_LOWEST) start = GRID_LOWEST;
        nports = (pin_mode == 2'b11) ? 0 : int'(pin_mode) + 1;
        port_mask  = '0;
        upper_mask = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (NUM_PINS - 1 - p < nports) port_mask[p] = 1'b1;
            if (p >= start) upper_mask[p] = 1'b1;
        end
    end

    always_ff @(posedge clk) rst_q <= rst;

    // R7: one clock after reset was sampled, every pin is low
    always @(posedge clk) begin
        if (rst_q) begin
            a_r7_reset_quiet: assert (drive == '0);
        end
    end

    // R1: tick advances the phase by one
    a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
        (osc_en && phase_cnt != LAST) |=> (phase_cnt == $past(phase_cnt) + PH_W'(1)));

    // R1: the phase wraps straight back to zero
    a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        (osc_en && phase_cnt == LAST) |=> (phase_cnt == '0));

    // R1: no tick, no movement
    a_r1_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> $stable(phase_cnt));

    // R4: the timing index moves only at a period boundary
    a_r4_index_hold: assert property (@(posedge clk) disable iff (rst)
        !(osc_en && phase_cnt == LAST) |=> $stable(timing_idx));

    // R2: dark window blanks every scan pin
    a_r2_blank_dark: assert property (@(posedge clk) disable iff (rst)
        blank_win |=> ((drive & ~$past(port_mask)) == '0));

    // R5: display off blanks every scan pin
    a_r5_off_dark: assert property (@(posedge clk) disable iff (rst)
        !disp_on |=> ((drive & ~$past(port_mask)) == '0));

    // R8: at most one grid pin lit at a time
    a_r8_single_grid: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $onehot0(drive & ~$past(port_mask) & $past(upper_mask)));

endmodule

bind vfd_scan_ctrl vfd_scan_chk #(
    .NUM_PINS    (NUM_PINS),
    .PERIOD      (PERIOD),
    .GRID_BASE   (GRID_BASE),
    .GRID_LOWEST (GRID_LOWEST),
    .IDX_W       (IDX_W),
    .PH_W        (PH_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .osc_en     (osc_en),
    .disp_on    (disp_on),
    .pin_mode   (pin_mode),
    .grid_sel   (grid_sel),
    .drive      (drive),
    .phase_cnt  (phase_cnt),
    .timing_idx (timing_idx),
    .blank_win  (blank_win)
);

// File: tb/vfd_scan_ctrl_tb.sv
module vfd_scan_ctrl_tb;

    localparam int NP  = 25;
    localparam int PER = 768;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_en = 1'b0;
    logic        disp_on = 1'b0;
    logic [1:0]  duty_sel = 2'b00;
    logic [3:0]  count_sel = 4'd0;
    logic [3:0]  grid_sel = 4'd0;
    logic [1:0]  pin_mode = 2'b11;
    logic [2:0]  port_data = 3'b000;
    logic [NP-1:0] ram_rdata = '0;

    logic          ram_rd;
    logic [3:0]    ram_addr;
    logic [NP-1:0] drive;
    logic [9:0]    phase_cnt;
    logic [3:0]    timing_idx;
    logic          blank_win;

    always #10 clk = ~clk;

    vfd_scan_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .osc_en     (osc_en),
        .disp_on    (disp_on),
        .duty_sel   (duty_sel),
        .count_sel  (count_sel),
        .grid_sel   (grid_sel),
        .pin_mode   (pin_mode),
        .port_data  (port_data),
        .ram_rdata  (ram_rdata),
        .ram_rd     (ram_rd),
        .ram_addr   (ram_addr),
        .drive      (drive),
        .phase_cnt  (phase_cnt),
        .timing_idx (timing_idx),
        .blank_win  (blank_win)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit live = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Display RAM: one word per timing, one cycle read latency.
    logic [NP-1:0] mem [16];

    task automatic fill(input int seed);
        for (int i = 0; i < 16; i++) begin
            mem[i] = NP'((i + 1) * (seed * 40503 + 7) ^ (seed << (i % 9)));
        end
    endtask

    always @(posedge clk) begin
        if (ram_rd) ram_rdata <= mem[ram_addr];
    end

    // Behavioural reference
    int            m_phase, m_idx, m_n, m_s, m_np;
    bit            m_primed, m_pend, m_off;
    logic [NP-1:0] m_segn, m_segc, m_exp;

    always @(posedge clk) begin : model
        int n, s, np, nxt, lit, dark, gp;
        bit rd, wrap;
        logic [NP-1:0] e;
        if (rst) begin
            m_phase <= 0; m_idx <= 0; m_primed <= 1'b0; m_pend <= 1'b0;
            m_segn <= '0; m_segc <= '0; m_exp <= '0;
            m_n <= 16; m_s <= 18; m_np <= 0; m_off <= 1'b1;
        end else begin
            n  = (count_sel > 4'd11) ? 5 : 16 - int'(count_sel);
            s  = (grid_sel > 4'd10) ? 8 : 18 - int'(grid_sel);
            np = (pin_mode == 2'b11) ? 0 : int'(pin_mode) + 1;
            case (duty_sel)
                2'b11:   lit = 15;
                2'b10:   lit = 6;
                2'b01:   lit = 4;
                default: lit = 3;
            endcase
            dark = PER * (16 - lit) / 16;
            nxt  = (m_idx == 0 || m_idx >= n) ? n - 1 : m_idx - 1;
            rd   = osc_en && (m_phase == PER - 3);
            wrap = osc_en && (m_phase == PER - 1);

            if (live) begin
                chk("R2 dark window flag", int'(blank_win), (m_phase < dark) ? 1 : 0);
                chk("R9 read strobe", int'(ram_rd), int'(rd));
                if (rd) chk("R9 read address", int'(ram_addr), nxt);
            end

            e = '0;
            if (disp_on && m_primed && m_phase >= dark) begin
                for (int p = 0; p < NP; p++) begin
                    if (p < s) e[p] = m_segc[p];
                end
                gp = s + n - 1 - m_idx;
                if (m_idx < n && gp < NP) e[gp] = 1'b1;
            end
            for (int k = 0; k < np; k++) e[NP-1-k] = port_data[k];

            if (osc_en) m_phase <= (m_phase == PER - 1) ? 0 : m_phase + 1;
            if (m_pend) m_segn <= ram_rdata;
            m_pend <= rd;
            if (wrap) begin
                m_idx    <= nxt;
                m_primed <= 1'b1;
                m_segc   <= m_segn;
            end
            m_exp <= e;
            m_n   <= n;
            m_s   <= s;
            m_np  <= np;
            m_off <= !disp_on;
        end
    end

    // Output comparison, away from the active edge
    always @(negedge clk) begin : compare
        logic [NP-1:0] pm, sm, gm;
        string t;
        if (live) begin
            pm = '0; sm = '0;
            for (int k = 0; k < m_np; k++) pm[NP-1-k] = 1'b1;
            for (int k = 0; k < NP; k++) if (k < m_s) sm[k] = 1'b1;
            sm = sm & ~pm;
            gm = ~sm & ~pm;
            chk("R1 phase counter", int'(phase_cnt), m_phase);
            t = (m_idx == m_n - 1) ? "R3 top timing index" : "R4 timing index";
            chk(t, int'(timing_idx), m_idx);
            chk("R6 port pins", int'(drive & pm), int'(m_exp & pm));
            t = m_off ? "R5 segment pins off" : "R9 segment pins";
            chk(t, int'(drive & sm), int'(m_exp & sm));
            t = m_off ? "R5 grid pins off" : "R8 grid pins";
            chk(t, int'(drive & gm), int'(m_exp & gm));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog (R1 scan progress): actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(input logic [1:0] d, input logic [3:0] tc, input logic [3:0] gs,
                       input logic [1:0] pm, input logic [2:0] pd, input logic on,
                       input int cyc, input int div, input int seed);
        @(negedge clk);
        duty_sel  = d;
        count_sel = tc;
        grid_sel  = gs;
        pin_mode  = pm;
        port_data = pd;
        disp_on   = on;
        fill(seed);
        for (int c = 0; c < cyc; c++) begin
            osc_en = ((c % div) == 0);
            @(negedge clk);
        end
    endtask

    initial begin
        fill(3);
        repeat (3) @(negedge clk);
        chk("R7 drive in reset", int'(drive), 0);
        chk("R7 phase in reset", int'(phase_cnt), 0);
        chk("R7 index in reset", int'(timing_idx), 0);
        rst  = 1'b0;
        live = 1'b1;

        // 16 timings, brightest step, grids from pin 18 (upper ones off-chip)
        run(2'b11, 4'd0, 4'd0, 2'b11, 3'b000, 1'b1, 17 * PER + 50, 1, 11);
        // 5 timings, dimmest step, grids from pin 8, P0 as a port
        run(2'b00, 4'd11, 4'd10, 2'b00, 3'b101, 1'b1, 6 * PER, 1, 12);
        // 8 timings, 6/16, grids from pin 13, three ports, half-rate ticks
        run(2'b10, 4'd8, 4'd5, 2'b10, 3'b011, 1'b1, 18 * PER, 2, 13);
        // clamped codes: 5 timings, grids from pin 8, 4/16, two ports
        run(2'b01, 4'd15, 4'd15, 2'b01, 3'b110, 1'b1, 6 * PER, 1, 14);
        // count shrinks below the running index, duty changes mid-scan
        run(2'b11, 4'd4, 4'd2, 2'b00, 3'b001, 1'b1, 2 * PER + 100, 1, 15);
        run(2'b00, 4'd9, 4'd2, 2'b00, 3'b000, 1'b1, 3 * PER, 1, 16);
        // display off: only ports stay alive
        run(2'b11, 4'd6, 4'd6, 2'b01, 3'b011, 1'b0, 3 * PER, 1, 17);
        // back on with irregular ticks
        run(2'b10, 4'd10, 4'd4, 2'b11, 3'b000, 1'b1, 8 * PER, 3, 18);

        live = 1'b0;
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule